// File: doc/BRIEF.md
# Multi-block DMA channel sequencer

This block runs a single DMA channel through a chain of equal-length block transfers. Software programs a start source address, a start destination address and a block length in beats, then pulses `start`. Each beat reads one 32-bit word from the source over a request/acknowledge memory port and then writes that word to the destination. Both addresses advance by 4 bytes per beat.

At every block boundary each address follows its own rule, chosen by two control bits that are sampled at that moment. It can return to its programmed start, continue from where the block stopped, or repeat the start of the block that just ended. A pending status bit is set when the last write of a block is acknowledged. The interrupt output is that bit gated by an enable and a mask. When an address is set to reload and the interrupt is enabled and unmasked, the channel waits after the block until software pulses the clear input. The chain ends after the first block at whose end neither address is set to reload.

Top module: `dma_block_seq`

## Requirements
- R1: After reset the channel is idle: `chan_busy`, `xfer_done`, `blk_pending`, `blk_irq` and `cfg_err` are 0 and `mem_req` is 0. A `start` pulse while idle or done begins a transfer with a read at `cfg_src_addr`.
- R2: A beat is a read (`mem_we`=0) at the current source address, then a write (`mem_we`=1) at the current destination address carrying the word returned by the read. A request holds its address and direction until `mem_ack`.
- R3: A block has `cfg_blk_len` beats, and a length of 0 counts as 1. Within a block each address advances by 4 per beat.
- R4: An address whose reload bit is 1 at a block boundary starts the next block at its programmed start address.
- R5: An address whose reload bit is 0 and contiguous bit is 1 starts the next block at the address that follows the last one it used.
- R6: An address with both bits 0 starts the next block at the same address where the block just finished began.
- R7: When both contiguous bits are 1, the destination is treated as reloading and `cfg_err` goes to 1. `cfg_err` stays at 1 until the next accepted `start`, which sets it from the bits present then.
- R8: `blk_pending` is set once the final write of a block has been acknowledged, even when the mask is 1. `blk_irq` equals `blk_pending` AND `cfg_int_en` AND NOT `cfg_blk_mask`.
- R9: If either address reloads at a block boundary while `cfg_int_en`=1 and `cfg_blk_mask`=0, the channel stalls: it stays busy and issues no request.
- R10: A `blk_clr` pulse clears `blk_pending`. In a stall it also starts the next block.
- R11: If `cfg_int_en`=0 or `cfg_blk_mask`=1, the channel goes on to the next block without stalling.
- R12: At a block boundary where neither address reloads, the channel stops with `xfer_done`=1, `chan_busy`=0 and no further requests.
- R13: A `start` pulse while the channel is busy, including in a stall, has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Single-cycle start pulse |
| blk_clr | input | 1 | Single-cycle block status clear |
| cfg_src_addr | input | 32 | Programmed source start address |
| cfg_dst_addr | input | 32 | Programmed destination start address |
| cfg_blk_len | input | 12 | Beats per block (0 means 1) |
| cfg_src_reload | input | 1 | Source returns to its start each block |
| cfg_dst_reload | input | 1 | Destination returns to its start each block |
| cfg_src_contig | input | 1 | Source continues across blocks |
| cfg_dst_contig | input | 1 | Destination continues across blocks |
| cfg_int_en | input | 1 | Block interrupt enable |
| cfg_blk_mask | input | 1 | Block interrupt mask |
| mem_req | output | 1 | Memory request |
| mem_we | output | 1 | 1 for write, 0 for read |
| mem_addr | output | 32 | Memory byte address |
| mem_wdata | output | 32 | Write data |
| mem_rdata | input | 32 | Read data, valid with `mem_ack` on reads |
| mem_ack | input | 1 | Request accepted this cycle |
| blk_pending | output | 1 | Block-complete status |
| blk_irq | output | 1 | Block-complete interrupt |
| xfer_done | output | 1 | Transfer finished after its final block |
| chan_busy | output | 1 | Transfer in progress, stalls included |
| cfg_err | output | 1 | Both addresses were set contiguous |

## Verification
The embedded properties check, on every cycle, the stepping of each address and the boundary rules for reload and contiguous mode. They also check that requests hold until acknowledged, that read data reaches the write, that pending is set at each boundary, and how the controller chooses between stall, continue and finish. Some behaviour only the bench scenarios can show. Those are the complete address sequences across three-block chains, software changing the mode bits during a run or a stall, a start pulse ignored during a stall, the zero-length block, and the error flag being cleared on a later start.

// File: rtl/dma_block_seq_pkg.sv
package dma_block_seq_pkg;
  localparam int ADDR_W     = 32;
  localparam int DATA_W     = 32;
  localparam int LEN_W      = 12;
  localparam int BEAT_BYTES = DATA_W / 8;
  localparam int N_PTR      = 2;   // 0 = source, 1 = destination

  typedef logic [ADDR_W-1:0] addr_t;
  typedef logic [DATA_W-1:0] data_t;
  typedef logic [LEN_W-1:0]  len_t;

  typedef enum logic [2:0] {
    ST_IDLE, ST_READ, ST_WRITE, ST_BLK_END, ST_STALL, ST_DONE
  } seq_state_t;

  // a zero-length block moves one beat
  function automatic len_t beats_of(input len_t len);
    return (len == '0) ? len_t'(1) : len;
  endfunction

  function automatic addr_t beat_advance(input addr_t a);
    return a + addr_t'(BEAT_BYTES);
  endfunction

  // where an address begins the next block
  function automatic addr_t next_block_addr(input addr_t init, input addr_t blk_start,
                                            input addr_t cur, input logic reload,
                                            input logic contig);
    if (reload)      return init;
    else if (contig) return cur;
    else             return blk_start;
  endfunction
endpackage

// File: rtl/dma_addr_unit.sv
module dma_addr_unit
  import dma_block_seq_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  load,
  input  addr_t load_addr,
  input  logic  step,
  input  logic  blk_end,
  input  logic  reload,
  input  logic  contig,
  output addr_t cur_addr
);
  addr_t init_q, start_q, cur_q;
  addr_t boundary_addr;

  assign boundary_addr = next_block_addr(init_q, start_q, cur_q, reload, contig);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      init_q  <= '0;
      start_q <= '0;
      cur_q   <= '0;
    end else if (load) begin
      init_q  <= load_addr;
      start_q <= load_addr;
      cur_q   <= load_addr;
    end else if (blk_end) begin
      start_q <= boundary_addr;
      cur_q   <= boundary_addr;
    end else if (step) begin
      cur_q   <= beat_advance(cur_q);
    end
  end

  assign cur_addr = cur_q;

  AST_ADDR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    step && !load && !blk_end |=> cur_q == $past(cur_q) + addr_t'(BEAT_BYTES)); // R3
  AST_RELOAD_INIT: assert property (@(posedge clk) disable iff (!rst_n)
    blk_end && !load && reload |=> cur_q == init_q); // R4
  AST_CONTIG_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
    blk_end && !load && !reload && contig |=> $stable(cur_q)); // R5
  AST_REPEAT_START: assert property (@(posedge clk) disable iff (!rst_n)
    blk_end && !load && !reload && !contig |=> cur_q == $past(start_q)); // R6
endmodule

// File: rtl/dma_beat_count.sv
module dma_beat_count
  import dma_block_seq_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic load,
  input  len_t load_len,
  input  logic dec,
  output logic last_beat
);
  len_t cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    cnt_q <= '0;
    else if (load) cnt_q <= beats_of(load_len);
    else if (dec && cnt_q != '0) cnt_q <= cnt_q - len_t'(1);
  end

  assign last_beat = (cnt_q == len_t'(1));

  AST_LEN_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> cnt_q != '0); // R3
endmodule

// File: rtl/dma_seq_ctrl.sv
module dma_seq_ctrl
  import dma_block_seq_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start,
  input  logic       blk_clr,
  input  logic       mem_ack,
  input  logic       last_beat,
  input  logic       any_reload,
  input  logic       stall_en,
  output logic       accept,
  output logic       rd_en,
  output logic       wr_en,
  output logic       step,
  output logic       blk_end,
  output seq_state_t state
);
  seq_state_t state_q, state_d;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE, ST_DONE: if (start) state_d = ST_READ;
      ST_READ:          if (mem_ack) state_d = ST_WRITE;
      ST_WRITE:         if (mem_ack) state_d = last_beat ? ST_BLK_END : ST_READ;
      ST_BLK_END: begin
        if (!any_reload)   state_d = ST_DONE;
        else if (stall_en) state_d = ST_STALL;
        else               state_d = ST_READ;
      end
      ST_STALL:         if (blk_clr) state_d = ST_READ;
      default:          state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_IDLE;
    else        state_q <= state_d;
  end

  assign accept  = start && (state_q == ST_IDLE || state_q == ST_DONE);
  assign rd_en   = (state_q == ST_READ);
  assign wr_en   = (state_q == ST_WRITE);
  assign step    = wr_en && mem_ack;
  assign blk_end = (state_q == ST_BLK_END);
  assign state   = state_q;

  AST_STALL_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
    blk_end && any_reload && stall_en |=> state_q == ST_STALL); // R9
  AST_NO_STALL: assert property (@(posedge clk) disable iff (!rst_n)
    blk_end && any_reload && !stall_en |=> state_q == ST_READ); // R11
  AST_CLR_RESUME: assert property (@(posedge clk) disable iff (!rst_n)
    state_q == ST_STALL && blk_clr |=> state_q == ST_READ); // R10
  AST_FINAL_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    blk_end && !any_reload |=> state_q == ST_DONE); // R12
  AST_START_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    state_q == ST_STALL && start && !blk_clr |=> state_q == ST_STALL); // R13
endmodule

// File: rtl/dma_block_seq.sv
module dma_block_seq
  import dma_block_seq_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start,
  input  logic        blk_clr,
  input  logic [31:0] cfg_src_addr,
  input  logic [31:0] cfg_dst_addr,
  input  logic [11:0] cfg_blk_len,
  input  logic        cfg_src_reload,
  input  logic        cfg_dst_reload,
  input  logic        cfg_src_contig,
  input  logic        cfg_dst_contig,
  input  logic        cfg_int_en,
  input  logic        cfg_blk_mask,
  output logic        mem_req,
  output logic        mem_we,
  output logic [31:0] mem_addr,
  output logic [31:0] mem_wdata,
  input  logic [31:0] mem_rdata,
  input  logic        mem_ack,
  output logic        blk_pending,
  output logic        blk_irq,
  output logic        xfer_done,
  output logic        chan_busy,
  output logic        cfg_err
);
  seq_state_t state;
  logic accept, rd_en, wr_en, step, blk_end, last_beat;
  logic both_contig, dst_reload_eff, any_reload, stall_en;
  len_t  len_q, load_len;
  data_t data_q;
  logic  pending_q, cfg_err_q;

  addr_t ptr_load [N_PTR];
  logic  ptr_reload [N_PTR];
  logic  ptr_contig [N_PTR];
  addr_t ptr_addr [N_PTR];

  // configuration decoded at the boundary
  assign both_contig    = cfg_src_contig && cfg_dst_contig;
  assign dst_reload_eff = cfg_dst_reload || both_contig;
  assign any_reload     = cfg_src_reload || dst_reload_eff;
  assign stall_en       = cfg_int_en && !cfg_blk_mask;

  assign ptr_load[0]   = cfg_src_addr;
  assign ptr_load[1]   = cfg_dst_addr;
  assign ptr_reload[0] = cfg_src_reload;
  assign ptr_reload[1] = dst_reload_eff;
  assign ptr_contig[0] = cfg_src_contig;
  assign ptr_contig[1] = cfg_dst_contig;

  dma_seq_ctrl u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (start),
    .blk_clr    (blk_clr),
    .mem_ack    (mem_ack),
    .last_beat  (last_beat),
    .any_reload (any_reload),
    .stall_en   (stall_en),
    .accept     (accept),
    .rd_en      (rd_en),
    .wr_en      (wr_en),
    .step       (step),
    .blk_end    (blk_end),
    .state      (state)
  );

  for (genvar g = 0; g < N_PTR; g++) begin : g_ptr
    dma_addr_unit u_addr (
      .clk       (clk),
      .rst_n     (rst_n),
      .load      (accept),
      .load_addr (ptr_load[g]),
      .step      (step),
      .blk_end   (blk_end),
      .reload    (ptr_reload[g]),
      .contig    (ptr_contig[g]),
      .cur_addr  (ptr_addr[g])
    );
  end

  assign load_len = accept ? cfg_blk_len : len_q;

  dma_beat_count u_cnt (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (accept || blk_end),
    .load_len  (load_len),
    .dec       (step),
    .last_beat (last_beat)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      len_q     <= '0;
      data_q    <= '0;
      pending_q <= 1'b0;
      cfg_err_q <= 1'b0;
    end else begin
      if (accept) len_q <= cfg_blk_len;
      if (rd_en && mem_ack) data_q <= mem_rdata;
      if (blk_end)      pending_q <= 1'b1;
      else if (blk_clr) pending_q <= 1'b0;
      if (accept)                     cfg_err_q <= both_contig;
      else if (blk_end && both_contig) cfg_err_q <= 1'b1;
    end
  end

  assign mem_req     = rd_en || wr_en;
  assign mem_we      = wr_en;
  assign mem_addr    = wr_en ? ptr_addr[1] : ptr_addr[0];
  assign mem_wdata   = data_q;
  assign blk_pending = pending_q;
  assign blk_irq     = pending_q && cfg_int_en && !cfg_blk_mask;
  assign xfer_done   = (state == ST_DONE);
  assign chan_busy   = (state != ST_IDLE) && (state != ST_DONE);
  assign cfg_err     = cfg_err_q;

  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_ack |=> mem_req && $stable(mem_addr) && $stable(mem_we)); // R2
  AST_WDATA_FROM_READ: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_we && mem_ack |=> mem_wdata == $past(mem_rdata)); // R2
  AST_PEND_AT_END: assert property (@(posedge clk) disable iff (!rst_n)
    blk_end |=> blk_pending); // R8
  AST_CLR_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
    blk_clr && !blk_end |=> !blk_pending); // R10
  AST_CFG_ERR: assert property (@(posedge clk) disable iff (!rst_n)
    blk_end && both_contig |=> cfg_err); // R7
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_done |-> !mem_req && !chan_busy); // R12
endmodule

// File: tb/dma_block_seq_tb.sv
module dma_block_seq_tb;
  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic        rst_n, start, blk_clr;
  logic [31:0] cfg_src_addr, cfg_dst_addr;
  logic [11:0] cfg_blk_len;
  logic        cfg_src_reload, cfg_dst_reload, cfg_src_contig, cfg_dst_contig;
  logic        cfg_int_en, cfg_blk_mask;
  logic        mem_req, mem_we, mem_ack;
  logic [31:0] mem_addr, mem_wdata, mem_rdata;
  logic        blk_pending, blk_irq, xfer_done, chan_busy, cfg_err;

  dma_block_seq u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .blk_clr(blk_clr),
    .cfg_src_addr(cfg_src_addr), .cfg_dst_addr(cfg_dst_addr), .cfg_blk_len(cfg_blk_len),
    .cfg_src_reload(cfg_src_reload), .cfg_dst_reload(cfg_dst_reload),
    .cfg_src_contig(cfg_src_contig), .cfg_dst_contig(cfg_dst_contig),
    .cfg_int_en(cfg_int_en), .cfg_blk_mask(cfg_blk_mask),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_rdata(mem_rdata), .mem_ack(mem_ack),
    .blk_pending(blk_pending), .blk_irq(blk_irq), .xfer_done(xfer_done),
    .chan_busy(chan_busy), .cfg_err(cfg_err)
  );

  int checks = 0;
  int errors = 0;
  int lat = 0;
  int wr_seen = 0;
  string scn = "R1";
  logic [31:0] exp_addr [$];
  bit          exp_we   [$];
  logic [31:0] exp_data [$];

  function automatic logic [31:0] pat(input logic [31:0] a);
    return {a[15:0] ^ 16'h3C5A, ~a[15:0]};
  endfunction

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, expv);
    end
  endtask

  // reference: one block of beats as the requirements describe them (R2, R3)
  task automatic push_block(input logic [31:0] s, input logic [31:0] d, input int n);
    for (int i = 0; i < n; i++) begin
      exp_addr.push_back(s + 32'(4*i)); exp_we.push_back(1'b0); exp_data.push_back('0);
      exp_addr.push_back(d + 32'(4*i)); exp_we.push_back(1'b1); exp_data.push_back(pat(s + 32'(4*i)));
    end
  endtask

  // memory model: acknowledges after lat waiting cycles, checks each handshake
  initial begin
    int waitc;
    waitc = 0;
    mem_ack = 1'b0;
    mem_rdata = '0;
    forever begin
      @(negedge clk);
      if (rst_n && mem_req && waitc >= lat) begin
        mem_ack = 1'b1;
        waitc = 0;
        if (exp_addr.size() == 0) begin
          chk(1'b0, {scn, " unexpected request"}, mem_addr, '0);
        end else begin
          logic [31:0] ea, ed;
          bit ew;
          ea = exp_addr.pop_front(); ew = exp_we.pop_front(); ed = exp_data.pop_front();
          chk(mem_we == ew, {scn, " R2 direction"}, 32'(mem_we), 32'(ew));
          chk(mem_addr == ea, {scn, " R3 address"}, mem_addr, ea);
          if (ew) chk(mem_wdata == ed, {scn, " R2 write data"}, mem_wdata, ed);
        end
        if (mem_we) wr_seen++;
        else mem_rdata = pat(mem_addr);
      end else begin
        mem_ack = 1'b0;
        if (mem_req) waitc++;
      end
    end
  end

  // per-cycle reference for the interrupt and status outputs
  initial begin
    forever begin
      @(posedge clk); #5;
      if (rst_n) begin
        chk(blk_irq == (blk_pending && cfg_int_en && !cfg_blk_mask), "R8 irq gating",
            32'(blk_irq), 32'(blk_pending && cfg_int_en && !cfg_blk_mask));
        if (!chan_busy) chk(!mem_req, "R12 no request when not busy", 32'(mem_req), 0);
        chk(!(chan_busy && xfer_done), "R12 busy and done exclusive", 32'(xfer_done), 0);
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=%h expected=%h", 32'd100000, 32'd0);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  task automatic pulse_start();
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
  endtask

  task automatic pulse_clr();
    @(negedge clk); blk_clr = 1'b1;
    @(negedge clk); blk_clr = 1'b0;
  endtask

  task automatic wait_writes(input int n);
    while (wr_seen < n) begin @(posedge clk); #1; end
    @(negedge clk);
  endtask

  task automatic wait_done();
    while (!xfer_done) begin @(posedge clk); #1; end
    @(negedge clk);
  endtask

  task automatic setup(input string tag, input logic [31:0] s, input logic [31:0] d,
                       input logic [11:0] len, input bit sr, input bit dr, input bit sc,
                       input bit dc, input bit ie, input bit mk, input int l);
    pulse_clr();
    @(negedge clk);
    scn = tag; lat = l; wr_seen = 0;
    cfg_src_addr = s; cfg_dst_addr = d; cfg_blk_len = len;
    cfg_src_reload = sr; cfg_dst_reload = dr; cfg_src_contig = sc; cfg_dst_contig = dc;
    cfg_int_en = ie; cfg_blk_mask = mk;
  endtask

  task automatic end_checks(input string tag, input bit exp_pend);
    chk(exp_addr.size() == 0, {tag, " all beats issued"}, 32'(exp_addr.size()), 0);
    chk(xfer_done && !chan_busy, {tag, " R12 done after final block"}, 32'(xfer_done), 1);
    chk(blk_pending == exp_pend, {tag, " R8 pending after final block"}, 32'(blk_pending), 32'(exp_pend));
  endtask

  initial begin
    rst_n = 1'b0; start = 1'b0; blk_clr = 1'b0;
    cfg_src_addr = '0; cfg_dst_addr = '0; cfg_blk_len = '0;
    cfg_src_reload = 0; cfg_dst_reload = 0; cfg_src_contig = 0; cfg_dst_contig = 0;
    cfg_int_en = 0; cfg_blk_mask = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(!chan_busy && !xfer_done, "R1 reset busy/done", {30'd0, chan_busy, xfer_done}, 0);
    chk(!blk_pending && !blk_irq && !cfg_err && !mem_req, "R1 reset status",
        {28'd0, blk_pending, blk_irq, cfg_err, mem_req}, 0);

    // single block, no reload: R1 R3 R8 R10 R12
    setup("R1", 32'h0000_0100, 32'h0000_0800, 12'd4, 0, 0, 0, 0, 1, 0, 0);
    push_block(32'h100, 32'h800, 4);
    pulse_start();
    chk(chan_busy, "R1 busy after start", 32'(chan_busy), 1);
    wait_done();
    end_checks("R1", 1'b1);
    chk(blk_irq, "R8 irq raised when enabled", 32'(blk_irq), 1);
    pulse_clr();
    chk(!blk_pending && !blk_irq, "R10 clear drops pending", {30'd0, blk_pending, blk_irq}, 0);

    // source reload, destination contiguous, interrupt disabled: R4 R5 R11
    setup("R4", 32'h0000_2000, 32'h0000_9000, 12'd3, 1, 0, 0, 1, 0, 0, 1);
    push_block(32'h2000, 32'h9000, 3);
    push_block(32'h2000, 32'h900C, 3);
    push_block(32'h2000, 32'h9018, 3);
    pulse_start();
    wait_writes(7);
    cfg_src_reload = 0;
    wait_done();
    end_checks("R11", 1'b1);
    chk(!blk_irq, "R8 irq low with enable off", 32'(blk_irq), 0);

    // masked: source contiguous, destination reload: R5 R8 R11
    setup("R5", 32'h0000_3000, 32'h0000_A000, 12'd2, 0, 1, 1, 0, 1, 1, 0);
    push_block(32'h3000, 32'hA000, 2);
    push_block(32'h3008, 32'hA000, 2);
    pulse_start();
    wait_writes(3);
    cfg_dst_reload = 0;
    wait_done();
    end_checks("R11", 1'b1);
    chk(!blk_irq, "R8 pending set while masked, irq low", 32'(blk_irq), 0);

    // stall sequence: R5 R6 R9 R10 R13
    setup("R9", 32'h0000_1000, 32'h0000_8000, 12'd2, 0, 1, 1, 0, 1, 0, 1);
    push_block(32'h1000, 32'h8000, 2);
    push_block(32'h1008, 32'h8000, 2);
    push_block(32'h1008, 32'h8000, 2);
    pulse_start();
    wait_writes(2);
    repeat (3) @(negedge clk);
    for (int i = 0; i < 6; i++) begin
      chk(chan_busy && !mem_req, "R9 stalled, no request", {30'd0, chan_busy, mem_req}, 32'd2);
      chk(blk_irq, "R9 irq during stall", 32'(blk_irq), 1);
      @(negedge clk);
    end
    pulse_start();
    repeat (3) @(negedge clk);
    chk(chan_busy && !mem_req && !xfer_done, "R13 start ignored in stall",
        {29'd0, chan_busy, mem_req, xfer_done}, 32'd4);
    cfg_src_contig = 0;
    pulse_clr();
    chk(!blk_pending, "R10 clear in stall drops pending", 32'(blk_pending), 0);
    wait_writes(4);
    repeat (3) @(negedge clk);
    chk(chan_busy && !mem_req && blk_pending, "R9 second stall",
        {29'd0, chan_busy, mem_req, blk_pending}, 32'd5);
    cfg_dst_reload = 0;
    pulse_clr();
    wait_done();
    end_checks("R6", 1'b1);

    // both contiguous: R7
    setup("R7", 32'h0000_4000, 32'h0000_B000, 12'd2, 0, 0, 1, 1, 0, 0, 2);
    push_block(32'h4000, 32'hB000, 2);
    push_block(32'h4008, 32'hB000, 2);
    pulse_start();
    chk(cfg_err, "R7 error flag on start", 32'(cfg_err), 1);
    wait_writes(3);
    cfg_dst_contig = 0;
    wait_done();
    end_checks("R7", 1'b1);
    chk(cfg_err, "R7 error flag sticky", 32'(cfg_err), 1);

    // zero length: R3, error flag cleared on next start: R7
    setup("R3", 32'h0000_5000, 32'h0000_C000, 12'd0, 0, 0, 0, 0, 0, 0, 2);
    push_block(32'h5000, 32'hC000, 1);
    pulse_start();
    chk(!cfg_err, "R7 error flag cleared by start", 32'(cfg_err), 0);
    wait_done();
    end_checks("R3", 1'b1);
    chk(wr_seen == 1, "R3 zero length is one beat", 32'(wr_seen), 1);

    repeat (2) @(negedge clk);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule